// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block is an on-chip RAM built around one shared bit store. With plain widths the store holds 4,096 bits. With parity-style widths (multiples of nine) it holds 4,608 bits. Each of the two ports sets its own data width through a parameter. The depth of each port follows from that width, so data written at one width can be read back at another. Every word occupies a fixed stretch of one linear bit space, which makes the mapping between the two ports exact.

The default mode is simple dual-port: port A only writes and port B only reads. Setting `DUAL_WRITE` gives true dual-port operation, where both ports read and write. Both ports run on one clock. Each read returns, one cycle later, the contents at the address presented at the clock edge. A parameter pairing that the storage cannot support stops elaboration with an error.

Top module: `mwram`

## Requirements
- R1: A plain width W (1, 2, 4, 8, 16 or 32) gives a port depth of 4096/W. A parity width W (9, 18 or 36) gives 4608/W. Each port's address is $clog2(depth) bits wide, and the top address of each port reaches real storage.
- R2: In simple dual-port mode, two plain widths may pair and two parity widths may pair. A plain width paired with a parity width is rejected at elaboration.
- R3: In true dual-port mode, widths 32 and 36 are rejected on either port. Widths 1, 2, 4, 8 and 16 pair freely with each other. Widths 9 and 18 pair only with each other.
- R4: A word of width W at address a occupies linear bit positions a*W to a*W+W-1, and word bit 0 sits at the lowest position. So narrow address a*k+i is bits [i*Wn +: Wn] of wide word a.
- R5: Read data changes only at a clock edge. After an edge it holds the contents at the address sampled at that edge, taken before that edge's writes. A same-cycle read of a location being written returns the old data.
- R6: A write at an edge with the write enable high updates exactly the addressed bits. The new value is visible to reads sampled at later edges.
- R7: While synchronous reset is high at an edge, both read outputs become zero. Reset does not alter stored contents.
- R8: In simple dual-port mode, `b_we` and `b_wdata` have no effect on storage, and `a_rdata` stays zero.
- R9: In true dual-port mode, writes from both ports in the same cycle to non-overlapping bits both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_rdata | output | A_WIDTH | Port A registered read data (zero in simple dual-port mode) |
| b_we | input | 1 | Port B write enable (true dual-port mode only) |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data (true dual-port mode only) |
| b_rdata | output | B_WIDTH | Port B registered read data |

## Verification
The bench builds one instance for every legal width pairing in both modes. It checks each instance against a linear bit-array model, so a lane-order or address-scaling fault in the wide-to-narrow mapping shows up as swapped or shifted slices. It forces the read address onto the word being written so that a write-first design, which returns new data too early, fails. It drives the port B write inputs in simple dual-port mode to catch a design that lets them corrupt storage. It resets mid-run and then reads back, catching a design that clears memory or leaves stale read data. The package legality rules are compared against an independent table, so a rule that admits mixed families or the widest shapes in true dual-port mode is reported.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int PLAIN_BITS  = 4096;
  localparam int PARITY_BITS = 4608;

  function automatic bit mw_is_plain(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
  endfunction

  function automatic bit mw_is_parity(input int w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic int mw_capacity(input int w);
    return mw_is_parity(w) ? PARITY_BITS : PLAIN_BITS;
  endfunction

  function automatic int mw_depth(input int w);
    return (w > 0) ? mw_capacity(w) / w : 1;
  endfunction

  // Legal shape pairing for the selected mode.
  function automatic bit mw_legal(input int wa, input int wb, input bit dual);
    bit same_family;
    same_family = (mw_is_plain(wa) && mw_is_plain(wb)) ||
                  (mw_is_parity(wa) && mw_is_parity(wb));
    if (dual && (wa == 32 || wa == 36 || wb == 32 || wb == 36)) return 1'b0;
    return same_family;
  endfunction

endpackage

// File: rtl/mwram_cfg_check.sv
module mwram_cfg_check #(
  parameter int  A_WIDTH    = 8,
  parameter int  B_WIDTH    = 32,
  parameter bit  DUAL_WRITE = 1'b0
);
  import mwram_pkg::*;

  localparam bit CFG_OK = mw_legal(A_WIDTH, B_WIDTH, DUAL_WRITE);

  generate
    if (!CFG_OK) begin : g_reject
      $error("mwram: width pairing %0d/%0d not supported in mode %0d",
             A_WIDTH, B_WIDTH, DUAL_WRITE);
    end
  endgenerate
endmodule

// File: rtl/mwram_lane_map.sv
module mwram_lane_map #(
  parameter int AW    = 9,
  parameter int RATIO = 1,
  parameter int UIW   = 9
) (
  input  logic [AW-1:0]  addr,
  output logic [UIW-1:0] base
);
  localparam int SHIFT = $clog2(RATIO);

  generate
    if (SHIFT == 0) begin : g_direct
      assign base = UIW'(addr);
    end else begin : g_scaled
      assign base = {addr, {SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/mwram_core.sv
module mwram_core #(
  parameter int A_WIDTH    = 8,
  parameter int B_WIDTH    = 32,
  parameter bit DUAL_WRITE = 1'b0,
  parameter int A_AW       = 9,
  parameter int B_AW       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_we,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  output logic [A_WIDTH-1:0] a_rdata,
  input  logic               b_we,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_wdata,
  output logic [B_WIDTH-1:0] b_rdata
);
  import mwram_pkg::*;

  localparam int UNIT  = (A_WIDTH < B_WIDTH) ? A_WIDTH : B_WIDTH;
  localparam int UNITS = mw_capacity(UNIT) / UNIT;
  localparam int UIW   = $clog2(UNITS);
  localparam int RA    = A_WIDTH / UNIT;
  localparam int RB    = B_WIDTH / UNIT;

  logic [UNIT-1:0] store [UNITS];
  logic [UIW-1:0]  a_base;
  logic [UIW-1:0]  b_base;
  logic            b_wr;

  assign b_wr = DUAL_WRITE && b_we;

  mwram_lane_map #(.AW(A_AW), .RATIO(RA), .UIW(UIW)) u_map_a (
    .addr(a_addr), .base(a_base)
  );
  mwram_lane_map #(.AW(B_AW), .RATIO(RB), .UIW(UIW)) u_map_b (
    .addr(b_addr), .base(b_base)
  );

  // Writes: each port spreads its word over RATIO consecutive units.
  always_ff @(posedge clk) begin
    if (a_we) begin
      for (int i = 0; i < RA; i++) begin
        store[a_base + UIW'(i)] <= a_wdata[i*UNIT +: UNIT];
      end
    end
    if (b_wr) begin
      for (int i = 0; i < RB; i++) begin
        store[b_base + UIW'(i)] <= b_wdata[i*UNIT +: UNIT];
      end
    end
  end

  // Port B registered read, old data on collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else begin
      for (int i = 0; i < RB; i++) begin
        b_rdata[i*UNIT +: UNIT] <= store[b_base + UIW'(i)];
      end
    end
  end

  generate
    if (DUAL_WRITE) begin : g_a_read
      always_ff @(posedge clk) begin
        if (rst) begin
          a_rdata <= '0;
        end else begin
          for (int i = 0; i < RA; i++) begin
            a_rdata[i*UNIT +: UNIT] <= store[a_base + UIW'(i)];
          end
        end
      end
    end else begin : g_a_quiet
      assign a_rdata = '0;
    end
  endgenerate
endmodule

// File: rtl/mwram.sv
module mwram #(
  parameter int A_WIDTH    = 8,
  parameter int B_WIDTH    = 32,
  parameter bit DUAL_WRITE = 1'b0,
  localparam int A_AW = $clog2(mwram_pkg::mw_depth(A_WIDTH)),
  localparam int B_AW = $clog2(mwram_pkg::mw_depth(B_WIDTH))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_we,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  output logic [A_WIDTH-1:0] a_rdata,
  input  logic               b_we,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_wdata,
  output logic [B_WIDTH-1:0] b_rdata
);

  mwram_cfg_check #(
    .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .DUAL_WRITE(DUAL_WRITE)
  ) u_cfg ();

  mwram_core #(
    .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .DUAL_WRITE(DUAL_WRITE),
    .A_AW(A_AW), .B_AW(B_AW)
  ) u_core (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );
endmodule

// File: rtl/mwram_sva.sv
module mwram_sva #(
  parameter int A_WIDTH    = 8,
  parameter int B_WIDTH    = 32,
  parameter bit DUAL_WRITE = 1'b0,
  parameter int A_AW       = 9,
  parameter int B_AW       = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               a_we,
  input logic [A_AW-1:0]    a_addr,
  input logic               b_we,
  input logic [B_AW-1:0]    b_addr,
  input logic [A_WIDTH-1:0] a_rdata,
  input logic [B_WIDTH-1:0] b_rdata
);
  logic b_wr_seen;
  assign b_wr_seen = DUAL_WRITE && b_we;

  AST_B_RST_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (b_rdata == '0)); // R7

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(b_addr) && !$past(a_we) && !$past(b_wr_seen))
      |=> $stable(b_rdata)); // R5

  generate
    if (DUAL_WRITE) begin : g_tdp
      AST_A_RST_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_rdata == '0)); // R7
      AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(a_addr) && !$past(a_we) && !$past(b_we))
          |=> $stable(a_rdata)); // R5
    end else begin : g_sdp
      AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
        a_rdata == '0); // R8
    end
  endgenerate
endmodule

bind mwram mwram_sva #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .DUAL_WRITE(DUAL_WRITE),
  .A_AW(A_AW), .B_AW(B_AW)
) u_sva (
  .clk(clk), .rst(rst), .a_we(a_we), .a_addr(a_addr), .b_we(b_we),
  .b_addr(b_addr), .a_rdata(a_rdata), .b_rdata(b_rdata)
);

// File: tb/mwram_tb.sv
`timescale 1ns/1ps

module mwram_tb_lane #(
  parameter int WA  = 8,
  parameter int WB  = 32,
  parameter bit TDP = 1'b0
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output logic done
);
  localparam int CAP = (WA % 9 == 0) ? 4608 : 4096;
  localparam int DA  = CAP / WA;
  localparam int DB  = CAP / WB;
  localparam int AAW = $clog2(DA);
  localparam int BAW = $clog2(DB);

  logic           rst;
  logic           a_we, b_we;
  logic [AAW-1:0] a_addr;
  logic [BAW-1:0] b_addr;
  logic [WA-1:0]  a_wdata, a_rdata;
  logic [WB-1:0]  b_wdata, b_rdata;

  bit mdl [CAP];
  bit kn  [CAP];

  mwram #(.A_WIDTH(WA), .B_WIDTH(WB), .DUAL_WRITE(TDP)) u_dut (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  // Called at a falling edge with inputs already set.
  task automatic run_cycle(input string tag);
    logic [WB-1:0] expb, mb;
    logic [WA-1:0] expa, ma;
    for (int k = 0; k < WB; k++) begin
      expb[k] = mdl[int'(b_addr)*WB + k];
      mb[k]   = kn[int'(b_addr)*WB + k];
    end
    for (int k = 0; k < WA; k++) begin
      expa[k] = mdl[int'(a_addr)*WA + k];
      ma[k]   = kn[int'(a_addr)*WA + k];
    end
    if (rst) begin
      expb = '0; mb = '1; expa = '0; ma = '1;
    end
    if (!TDP) begin
      expa = '0; ma = '1;
    end
    if (!rst && a_we)
      for (int k = 0; k < WA; k++) begin
        mdl[int'(a_addr)*WA + k] = a_wdata[k];
        kn[int'(a_addr)*WA + k]  = 1'b1;
      end
    if (!rst && TDP && b_we)
      for (int k = 0; k < WB; k++) begin
        mdl[int'(b_addr)*WB + k] = b_wdata[k];
        kn[int'(b_addr)*WB + k]  = 1'b1;
      end
    @(posedge clk);
    @(negedge clk);
    if (mb != '0) begin
      checks++;
      if (((b_rdata ^ expb) & mb) != '0) begin
        fails++;
        $display("FAIL %s lane %0d/%0d/%0d port B: actual %h expected %h mask %h",
                 tag, WA, WB, TDP, b_rdata, expb, mb);
      end
    end
    if (ma != '0) begin
      checks++;
      if (((a_rdata ^ expa) & ma) != '0) begin
        fails++;
        $display("FAIL %s lane %0d/%0d/%0d port A: actual %h expected %h",
                 TDP ? tag : "R8", WA, WB, TDP, a_rdata, expa);
      end
    end
  endtask

  task automatic drive_random(input bit aligned);
    int abit, bbit;
    a_we    = 1'($urandom());
    a_addr  = AAW'($urandom() % DA);
    a_wdata = WA'({$urandom(), $urandom()});
    b_we    = 1'($urandom());
    b_wdata = WB'({$urandom(), $urandom()});
    if (aligned) b_addr = BAW'((int'(a_addr) * WA) / WB);
    else         b_addr = BAW'($urandom() % DB);
    abit = int'(a_addr) * WA;
    bbit = int'(b_addr) * WB;
    if (TDP && a_we && b_we && abit < bbit + WB && bbit < abit + WA) b_we = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst = 1'b1; a_we = 1'b0; b_we = 1'b0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    @(negedge clk);
    run_cycle("R7");
    run_cycle("R7");
    rst = 1'b0;
    // Fill every A address, B reads randomly.
    for (int n = 0; n < DA; n++) begin
      a_we = 1'b1; a_addr = AAW'(n); a_wdata = WA'({$urandom(), $urandom()});
      b_we = 1'b0; b_addr = BAW'($urandom() % DB);
      run_cycle("R6");
    end
    a_we = 1'b0;
    b_addr = BAW'(DB - 1); run_cycle("R1");
    b_addr = '0;           run_cycle("R1");
    if (TDP) begin
      a_addr = AAW'(DA - 1); b_addr = BAW'(1); run_cycle("R1");
    end
    for (int n = 0; n < 600; n++) begin
      drive_random(n % 3 == 0);
      if (n % 3 == 0) run_cycle("R5");
      else            run_cycle(TDP ? "R4/R9" : "R4/R8");
    end
    a_we = 1'b0; b_we = 1'b0; rst = 1'b1;
    run_cycle("R7");
    run_cycle("R7");
    rst = 1'b0;
    for (int n = 0; n < 24; n++) begin
      a_addr = AAW'($urandom() % DA);
      b_addr = BAW'($urandom() % DB);
      run_cycle("R7");
    end
    done = 1'b1;
  end
endmodule

module mwram_tb;
  localparam int NW    = 9;
  localparam int NP    = NW * NW;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int wtab(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 4;
      3: return 8;  4: return 16; 5: return 32;
      6: return 9;  7: return 18; default: return 36;
    endcase
  endfunction

  // Independent legality table: parity widths are the multiples of nine.
  function automatic bit tb_legal(input int wa, input int wb, input bit dual);
    if (dual && (wa >= 32 || wb >= 32)) return 1'b0;
    return (wa % 9 == 0) == (wb % 9 == 0);
  endfunction

  int   chk_s [NP]; int fl_s [NP]; logic dn_s [NP];
  int   chk_t [NP]; int fl_t [NP]; logic dn_t [NP];

  for (genvar i = 0; i < NW; i++) begin : g_a
    for (genvar j = 0; j < NW; j++) begin : g_b
      if (tb_legal(wtab(i), wtab(j), 1'b0)) begin : g_s
        mwram_tb_lane #(.WA(wtab(i)), .WB(wtab(j)), .TDP(1'b0)) u_lane (
          .clk(clk), .checks(chk_s[i*NW+j]), .fails(fl_s[i*NW+j]), .done(dn_s[i*NW+j])
        );
      end else begin : g_sn
        assign chk_s[i*NW+j] = 0;
        assign fl_s[i*NW+j]  = 0;
        assign dn_s[i*NW+j]  = 1'b1;
      end
      if (tb_legal(wtab(i), wtab(j), 1'b1)) begin : g_t
        mwram_tb_lane #(.WA(wtab(i)), .WB(wtab(j)), .TDP(1'b1)) u_lane (
          .clk(clk), .checks(chk_t[i*NW+j]), .fails(fl_t[i*NW+j]), .done(dn_t[i*NW+j])
        );
      end else begin : g_tn
        assign chk_t[i*NW+j] = 0;
        assign fl_t[i*NW+j]  = 0;
        assign dn_t[i*NW+j]  = 1'b1;
      end
    end
  end

  initial begin
    int  checks, failures, cyc;
    bit  all_done, got, exp;
    checks = 0; failures = 0; cyc = 0;
    // Legality rules: R2 simple dual-port, R3 true dual-port.
    for (int i = 0; i < NW; i++)
      for (int j = 0; j < NW; j++)
        for (int m = 0; m < 2; m++) begin
          exp = tb_legal(wtab(i), wtab(j), m[0]);
          got = mwram_pkg::mw_legal(wtab(i), wtab(j), m[0]);
          checks++;
          if (got != exp) begin
            failures++;
            $display("FAIL %s widths %0d/%0d: actual %0d expected %0d",
                     m ? "R3" : "R2", wtab(i), wtab(j), got, exp);
          end
        end
    all_done = 1'b0;
    while (!all_done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      all_done = 1'b1;
      for (int k = 0; k < NP; k++) if (!dn_s[k] || !dn_t[k]) all_done = 1'b0;
    end
    for (int k = 0; k < NP; k++) begin
      checks   += chk_s[k] + chk_t[k];
      failures += fl_s[k] + fl_t[k];
    end
    if (!all_done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule